// File: doc/BRIEF.md
# Seven-Level Folded-Reference PWM Gate Generator

This block drives the seven gate lines of a single-phase seven-level inverter built from two stages: a level stage that stacks DC sources through three gated switches (the other conducting positions are diodes), and a full bridge that sets the output sign. A phase accumulator steps through one line period. A parabolic approximation of the sine gives a non-negative magnitude for each half cycle, and a modulation index scales that magnitude. Three triangular carriers share one phase and are stacked in separate bands above zero. The scaled magnitude is compared with all three carriers at once.

The number of carriers that the magnitude exceeds gives the output level, from 0 to 3. A fixed table turns the level into the level-stage gate pattern, and the table keeps changes between neighbouring levels small. The sign bit of the phase picks which diagonal pair of the bridge conducts. The bridge therefore switches only at line rate and only when the reference crosses zero. The line tuning word and the carrier tuning word are set separately. The default ratio between them is 80, for example a 4 kHz carrier over a 50 Hz line.

Top module: `pd_spwm7`

## Requirements
- R1: While `rstN` is low at a clock edge, all seven gate outputs are low after that edge, and both accumulators are cleared to zero.
- R2: At an edge where `enable` is low, all gate outputs go low and both accumulators are cleared, so the next enabled run starts from phase 0 and carrier position 0.
- R3: At each enabled edge the line phase (16 bits) advances by `lineStep` and the carrier position (16 bits) advances by `carrStep`, both modulo 2^16. A phase with MSB 0 selects the positive pair, `brgGate` = 4'b0011. A phase with MSB 1 selects the negative pair, `brgGate` = 4'b1100.
- R4: The magnitude is computed as follows. With h = phase[14:0], mag = (h*(32768-h)) >> 16, which lies in the range 0..4096. The scaled reference is ref = (mag*modIdx) >> 8.
- R5: The shared carrier is tri = u[12] ? ~u[11:0] : u[11:0], where u = carrier[15:3]. It ranges from 0 to 4095.
- R6: The level is the number of k in {0,1,2} for which 3*ref > k*4096 + tri. With modIdx = 255 level 3 appears near the peak. With modIdx = 128 level 3 never appears.
- R7: `lvlGate` is {top, step, mid}. Level 0 gives 3'b000, level 1 gives 3'b001, level 2 gives 3'b011 and level 3 gives 3'b101.
- R8: The gate outputs are registered. The values after an enabled edge come from the accumulator values held before that edge.
- R9: Within a pair, both bridge bits are always equal. The positive pair and the negative pair are never on together.
- R10: While `enable` stays high, the bridge changes only by moving directly from one pair to the other, and it does so only where the phase MSB flips.
- R11: With `modIdx` = 0 the level gates stay at 3'b000, while the bridge still follows the half-cycle sign.
- R12: `lvlGate` only ever takes one of the four codes listed in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run; low forces gates off and restarts phase |
| modIdx | input | 8 | Modulation index, scales reference magnitude |
| lineStep | input | 16 | Line phase tuning word |
| carrStep | input | 16 | Carrier tuning word |
| lvlGate | output | 3 | Level-stage gates {top, step, mid} |
| brgGate | output | 4 | Bridge gates: [1:0] positive pair, [3:2] negative pair |

## Verification
A bit-exact reference model steps both accumulators and predicts every output cycle. This catches a design that compares with the wrong band offset or a misplaced triangle fold, because it would pick the wrong level near band edges, and a design that taps the wrong phase bit for the sign, because it would flip the bridge away from zero crossings. The bench looks for level 3 at full index and makes sure level 3 never appears at half index, so a carrier stack with the wrong scale shows up. The zero-index run shows up any leak from the level stage. A disable in the middle of a run shows up a design that resumes from the old phase instead of zero.

// File: rtl/pd7_pkg.sv
package pd7_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;  // step both accumulators
    logic clear;    // restart both accumulators at zero
  } pd7Strobe_t;

  // level -> {top, step, mid}; neighbours differ by one gate except 2<->3
  function automatic logic [2:0] levelToGates(input logic [1:0] level);
    case (level)
      2'd0:    return 3'b000;
      2'd1:    return 3'b001;
      2'd2:    return 3'b011;
      default: return 3'b101;
    endcase
  endfunction

endpackage

// File: rtl/pd7_datapath.sv
module pd7_datapath
  import pd7_pkg::*;
#(
  parameter int PHASE_W = 16,
  parameter int CARR_W  = 16,
  parameter int MAG_W   = 12,
  parameter int MI_W    = 8,
  parameter int NCARR   = 3
) (
  input  logic               clk,
  input  pd7Strobe_t         strb,
  input  logic [MI_W-1:0]    modIdx,
  input  logic [PHASE_W-1:0] lineStep,
  input  logic [CARR_W-1:0]  carrStep,
  output logic [1:0]         level,
  output logic               negHalf
);
  localparam int HALF_W = PHASE_W - 1;
  localparam int PROD_W = 2 * HALF_W + 1;
  localparam int MAG_SH = 2 * HALF_W - 2 - MAG_W;
  localparam int SP_W   = MAG_W + 1 + MI_W;
  localparam int CMP_W  = MAG_W + 3;
  localparam int TRI_SH = CARR_W - MAG_W - 1;

  logic [PHASE_W-1:0] phaseAcc;
  logic [CARR_W-1:0]  carrAcc;

  always_ff @(posedge clk) begin
    if (strb.clear) begin
      phaseAcc <= '0;
      carrAcc  <= '0;
    end else if (strb.advance) begin
      phaseAcc <= phaseAcc + lineStep;
      carrAcc  <= carrAcc + carrStep;
    end
  end

  // folded parabolic magnitude of the half cycle
  logic [HALF_W-1:0] halfPh;
  logic [HALF_W:0]   halfComp;
  logic [PROD_W-1:0] prod;
  logic [MAG_W:0]    mag;
  logic [SP_W-1:0]   scaledProd;
  logic [MAG_W:0]    refMag;

  assign halfPh     = phaseAcc[HALF_W-1:0];
  assign negHalf    = phaseAcc[PHASE_W-1];
  assign halfComp   = (HALF_W+1)'(1 << HALF_W) - {1'b0, halfPh};
  assign prod       = PROD_W'(halfPh) * PROD_W'(halfComp);
  assign mag        = (MAG_W+1)'(prod >> MAG_SH);
  assign scaledProd = SP_W'(mag) * SP_W'(modIdx);
  assign refMag     = (MAG_W+1)'(scaledProd >> MI_W);

  // shared triangle, folded from the carrier accumulator
  logic [MAG_W:0]   carrTop;
  logic [MAG_W-1:0] tri12;
  assign carrTop = (MAG_W+1)'(carrAcc >> TRI_SH);
  assign tri12   = carrTop[MAG_W] ? ~carrTop[MAG_W-1:0] : carrTop[MAG_W-1:0];

  // reference times NCARR against each band-shifted carrier
  logic [CMP_W-1:0] refTimes;
  logic [NCARR-1:0] above;
  assign refTimes = CMP_W'(refMag) * CMP_W'(NCARR);

  for (genvar k = 0; k < NCARR; k++) begin : g_band
    logic [CMP_W-1:0] bandCarr;
    assign bandCarr = (CMP_W'(k) << MAG_W) + CMP_W'(tri12);
    assign above[k] = refTimes > bandCarr;
  end

  always_comb begin
    level = '0;
    for (int k = 0; k < NCARR; k++) level = level + 2'(above[k]);
  end

endmodule

// File: rtl/pd7_ctrl.sv
module pd7_ctrl
  import pd7_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [1:0] level,
  input  logic       negHalf,
  output pd7Strobe_t strb,
  output logic [2:0] lvlGate,
  output logic [3:0] brgGate
);
  assign strb.clear   = !rstN || !enable;
  assign strb.advance = rstN && enable;

  always_ff @(posedge clk) begin
    if (strb.clear) begin
      lvlGate <= '0;
      brgGate <= '0;
    end else begin
      lvlGate <= levelToGates(level);
      brgGate <= negHalf ? 4'b1100 : 4'b0011;
    end
  end

endmodule

// File: rtl/pd_spwm7.sv
module pd_spwm7
  import pd7_pkg::*;
#(
  parameter int PHASE_W = 16,
  parameter int CARR_W  = 16,
  parameter int MAG_W   = 12,
  parameter int MI_W    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [MI_W-1:0]    modIdx,
  input  logic [PHASE_W-1:0] lineStep,
  input  logic [CARR_W-1:0]  carrStep,
  output logic [2:0]         lvlGate,
  output logic [3:0]         brgGate
);
  localparam int LEVELS = 7;
  localparam int NCARR  = (LEVELS - 1) / 2;

  pd7Strobe_t strb;
  logic [1:0] level;
  logic       negHalf;

  pd7_datapath #(
    .PHASE_W(PHASE_W), .CARR_W(CARR_W), .MAG_W(MAG_W),
    .MI_W(MI_W), .NCARR(NCARR)
  ) u_dp (
    .clk(clk), .strb(strb), .modIdx(modIdx), .lineStep(lineStep),
    .carrStep(carrStep), .level(level), .negHalf(negHalf)
  );

  pd7_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .level(level),
    .negHalf(negHalf), .strb(strb), .lvlGate(lvlGate), .brgGate(brgGate)
  );

endmodule

// File: rtl/pd7_checker.sv
module pd7_checker (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic [2:0] lvlGate,
  input logic [3:0] brgGate
);
  AST_RESET_LOW: assert property (@(posedge clk)
    !rstN |=> (lvlGate == 3'b000 && brgGate == 4'b0000)); // R1

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (lvlGate == 3'b000 && brgGate == 4'b0000)); // R2

  AST_PAIR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    (brgGate[0] == brgGate[1]) && (brgGate[2] == brgGate[3])
    && !(brgGate[0] && brgGate[2])); // R9

  AST_BRIDGE_SWAP: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && $past(brgGate) != 4'b0000
     && brgGate != $past(brgGate))
    |-> (brgGate == {$past(brgGate[1:0]), $past(brgGate[3:2])})); // R10

  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rstN)
    lvlGate inside {3'b000, 3'b001, 3'b011, 3'b101}); // R12

endmodule

bind pd_spwm7 pd7_checker u_chk (
  .clk(clk), .rstN(rstN), .enable(enable),
  .lvlGate(lvlGate), .brgGate(brgGate)
);

// File: tb/tb_pd_spwm7.sv
module tb_pd_spwm7;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  modIdx = '0;
  logic [15:0] lineStep = '0;
  logic [15:0] carrStep = '0;
  logic [2:0]  lvlGate;
  logic [3:0]  brgGate;

  pd_spwm7 dut (
    .clk(clk), .rstN(rstN), .enable(enable), .modIdx(modIdx),
    .lineStep(lineStep), .carrStep(carrStep),
    .lvlGate(lvlGate), .brgGate(brgGate)
  );

  always #4 clk = ~clk;  // 125 MHz

  typedef struct {
    logic [2:0] lvl;
    logic [3:0] brg;
    string      lvlTag;
    string      brgTag;
  } expItem_t;

  expItem_t expQ[$];
  int errors = 0;
  int checks = 0;
  int lvl3Seen = 0;
  int lvl2Seen = 0;
  int mPhase = 0;
  int mCarr = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // independent model of R3..R7
  function automatic void predict(input int ph, input int cr, input int mi,
                                  output logic [2:0] l, output logic [3:0] b);
    int h, mg, rf, u, tr, lv;
    h  = ph & 32767;
    mg = (h * (32768 - h)) >>> 16;
    rf = (mg * mi) >>> 8;
    u  = (cr >>> 3) & 8191;
    tr = (u & 4096) != 0 ? (~u) & 4095 : u & 4095;
    lv = 0;
    for (int k = 0; k < 3; k++) if (3 * rf > k * 4096 + tr) lv++;
    case (lv)
      0: l = 3'b000;
      1: l = 3'b001;
      2: l = 3'b011;
      default: l = 3'b101;
    endcase
    b = (ph & 32768) != 0 ? 4'b1100 : 4'b0011;
  endfunction

  // driver: applies inputs for the next edge and pushes the expected outcome (R8)
  task automatic drive(input bit r, input bit e, input int mi, input int ls, input int cs);
    expItem_t it;
    @(negedge clk);
    rstN = r; enable = e; modIdx = 8'(mi); lineStep = 16'(ls); carrStep = 16'(cs);
    if (!r) begin
      it.lvl = 3'b000; it.brg = 4'b0000; it.lvlTag = "R1"; it.brgTag = "R1";
      mPhase = 0; mCarr = 0;
    end else if (!e) begin
      it.lvl = 3'b000; it.brg = 4'b0000; it.lvlTag = "R2"; it.brgTag = "R2";
      mPhase = 0; mCarr = 0;
    end else begin
      predict(mPhase, mCarr, mi, it.lvl, it.brg);
      it.lvlTag = (mi == 0) ? "R11" : "R4 R5 R6 R7 R8";
      it.brgTag = "R3 R8 R10";
      mPhase = (mPhase + ls) & 65535;
      mCarr  = (mCarr + cs) & 65535;
    end
    expQ.push_back(it);
  endtask

  task automatic run(input int n, input int mi, input int ls, input int cs);
    for (int i = 0; i < n; i++) drive(1'b1, 1'b1, mi, ls, cs);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 0, 0, 0);
  endtask

  // monitor: compares outputs 2 ns after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        check(lvlGate === it.lvl, it.lvlTag, int'(lvlGate), int'(it.lvl));
        check(brgGate === it.brg, it.brgTag, int'(brgGate), int'(it.brg));
        // R9 pair rule, R12 legal level code
        check(brgGate inside {4'b0000, 4'b0011, 4'b1100}, "R9", int'(brgGate), 3);
        check(lvlGate inside {3'b000, 3'b001, 3'b011, 3'b101}, "R12", int'(lvlGate), 0);
        if (lvlGate == 3'b101) lvl3Seen++;
        if (lvlGate == 3'b011) lvl2Seen++;
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) drive(1'b0, 1'b0, 0, 0, 0);          // R1
    // full index, ratio 80
    lvl3Seen = 0;
    run(11000, 255, 13, 1040);
    idle(3);
    check(lvl3Seen > 0, "R6 level 3 at full index", lvl3Seen, 1);
    // half index: level 3 must not appear (R6)
    lvl3Seen = 0; lvl2Seen = 0;
    run(6000, 128, 13, 1040);
    idle(3);
    check(lvl3Seen == 0, "R6 no level 3 at half index", lvl3Seen, 0);
    check(lvl2Seen > 0, "R6 level 2 at half index", lvl2Seen, 1);
    // zero index (R11)
    run(3000, 0, 40, 3200);
    // disable mid-run then resume from phase 0 (R2)
    run(700, 200, 300, 5000);
    idle(5);
    run(2500, 200, 300, 5000);
    // reset mid-run (R1)
    drive(1'b0, 1'b1, 200, 300, 5000);
    drive(1'b0, 1'b1, 200, 300, 5000);
    run(1500, 255, 1000, 777);
    idle(3);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule